// File: doc/BRIEF.md
# SPI Block-Transfer DMA Engine

This block connects a byte-wide SPI shift engine to a general-purpose byte-wide SRAM. Once software has programmed a transmit source pointer, a receive destination pointer and a byte count, it sets one enable bit. The engine then feeds bytes from RAM to the shift engine and writes the received bytes back to RAM, with no processor work per byte. It can run full-duplex, transmit-only or receive-only. It works whether the shift engine is clock master or clock slave. A completion flag drives an interrupt line.

While no block transfer is running, the shift engine stays usable one byte at a time through a data register, and the RAM port stays quiet. Full-duplex master operation with the serial output looped back to the serial input gives a memory-to-memory copy.

The register port is byte-wide with eight addresses. Address 0 is control. Addresses 1/2 hold the transmit pointer (low/high byte), 3/4 the receive pointer (low/high), 5/6 the byte count (low/high), and 7 is the data register. Read data is registered and appears one cycle after the address. The RAM port issues reads with one cycle of latency. The shift engine takes `spi_start` and the byte on `spi_tx_data`, and it returns a one-cycle `spi_done` together with `spi_rx_data`.

Top module: `spi_dma_ctrl`

## Requirements
- R1: Writing 1 to control bit 0 while idle starts a block transfer. The bit reads 1 until the transfer completes and then clears by itself.
- R2: A transfer moves exactly count+1 bytes, where count is the 10-bit value at addresses 5/6 (low byte at 5, bits 9:8 in bits 1:0 of address 6). This gives 1 to 1024 bytes.
- R3: Control bits 2:1 select the direction: 00 full-duplex, 01 transmit-only, 10 receive-only. In full-duplex, byte k sent comes from RAM at tx_pointer+k, and byte k received is written to RAM at rx_pointer+k.
- R4: In transmit-only mode, received bytes are discarded and no RAM write occurs.
- R5: In receive-only mode, every byte sent is 0xFF and no RAM read occurs.
- R6: Control bit 3 set selects master role: `spi_start` pulses once per byte. With bit 3 clear (slave role), `spi_start` never pulses and the engine advances only on `spi_done`.
- R7: After a transfer, the pointer of each active direction reads back advanced by the byte count moved. An inactive pointer and the count register read back unchanged.
- R8: Completion sets control bit 7 and raises `irq` in the same cycle the enable bit clears. Writing 1 to bit 7 clears both.
- R9: While idle, a write to address 7 sends that byte once (started at once in master role), and a read of address 7 returns the last received byte. No RAM access happens while idle.
- R10: While busy, writes to pointers, count and control bits 0 to 3 are ignored.
- R11: In full-duplex master mode with the serial output looped to the input, the destination region ends up equal to the source region.
- R12: In master role the next transmit byte is fetched during the current exchange, so `spi_start` for byte k+1 comes in the cycle after `spi_done` of byte k. This holds when an exchange lasts at least 4 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data, one cycle after address |
| irq | output | 1 | Completion interrupt (level) |
| spi_master | output | 1 | Role select to shift engine |
| spi_start | output | 1 | Start one byte exchange (master role) |
| spi_tx_data | output | 8 | Byte to shift out |
| spi_done | input | 1 | One-cycle pulse: exchange finished |
| spi_rx_data | input | 8 | Byte shifted in, valid with spi_done |
| ram_addr | output | 12 | RAM byte address |
| ram_re | output | 1 | RAM read request, data next cycle |
| ram_we | output | 1 | RAM write enable |
| ram_wdata | output | 8 | RAM write data |
| ram_rdata | input | 8 | RAM read data |

## Verification
Transfers run in full-duplex, transmit-only and receive-only modes, in master and slave roles, and with single-byte, short and full 1024-byte counts. Every sent byte and every RAM write is compared against a behavioural model. Master runs expose prefetch timing, because back-to-back starts appear only when the fetch overlaps the exchange. Slave runs at a slow external pace show that the engine waits on completion instead of its own timing. A loopback run separates a correct copy from pointer or ordering slips. Idle byte exchanges and register pokes during a busy transfer check that the RAM port stays silent and that the programmed state is protected.

// File: rtl/spi_dma_pkg.sv
package spi_dma_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_LOAD, ST_CAP, ST_START, ST_XFER} seq_st_t;

  localparam logic [1:0] DIR_FULL = 2'b00;
  localparam logic [1:0] DIR_TX   = 2'b01;
  localparam logic [1:0] DIR_RX   = 2'b10;

  localparam logic [2:0] A_CTRL  = 3'd0;
  localparam logic [2:0] A_TXLO  = 3'd1;
  localparam logic [2:0] A_TXHI  = 3'd2;
  localparam logic [2:0] A_RXLO  = 3'd3;
  localparam logic [2:0] A_RXHI  = 3'd4;
  localparam logic [2:0] A_CNTLO = 3'd5;
  localparam logic [2:0] A_CNTHI = 3'd6;
  localparam logic [2:0] A_DATA  = 3'd7;

  localparam logic [7:0] DUMMY_BYTE = 8'hFF;
endpackage

// File: rtl/spi_dma_bytereg.sv
// Register wider than a byte, loaded as low/high bytes, optionally stepping by one.
module spi_dma_bytereg #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_lo,
  input  logic         wr_hi,
  input  logic [7:0]   wdata,
  input  logic         step,
  output logic [W-1:0] q
);
  localparam int HW = W - 8;

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (step) begin
      q <= q + 1'b1;
    end else begin
      if (wr_lo) q[7:0]   <= wdata;
      if (wr_hi) q[W-1:8] <= wdata[HW-1:0];
    end
  end

  // R7: each step advances the pointer by exactly one
  p_step_r7: assert property (@(posedge clk) disable iff (rst)
    step |=> q == W'($past(q) + 1'b1));
endmodule

// File: rtl/spi_dma_seq.sv
// Transfer sequencer: fetch, exchange, write-back, count.
module spi_dma_seq
  import spi_dma_pkg::*;
#(
  parameter int CW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go_i,
  input  logic [1:0]    go_dir_i,
  input  logic          master_i,
  input  logic [CW-1:0] cnt_init_i,
  input  logic          pio_wr_i,
  input  logic [7:0]    pio_data_i,
  input  logic          spi_done_i,
  input  logic [7:0]    spi_rx_data_i,
  input  logic [7:0]    ram_rdata_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          spi_start_o,
  output logic [7:0]    spi_tx_data_o,
  output logic          ram_re_o,
  output logic          ram_we_o,
  output logic [7:0]    rx_last_o
);
  seq_st_t       st_q;
  logic          busy_q, nxt_vld_q, nxt_pend_q, pio_go_q;
  logic [CW-1:0] cnt_q;
  logic [1:0]    dir_q;
  logic [7:0]    tx_cur_q, nxt_q, rx_last_q;
  logic          tx_act, rx_act, fetch, last;

  assign tx_act = (dir_q != DIR_RX);
  assign rx_act = (dir_q != DIR_TX);
  assign last   = (cnt_q == '0);
  assign fetch  = (st_q == ST_XFER) && tx_act && !last && !nxt_vld_q &&
                  !nxt_pend_q && !spi_done_i;

  assign ram_re_o      = (st_q == ST_LOAD) || fetch;
  assign ram_we_o      = (st_q == ST_XFER) && spi_done_i && rx_act;
  assign done_o        = (st_q == ST_XFER) && spi_done_i && last;
  assign spi_start_o   = ((st_q == ST_START) && master_i) || pio_go_q;
  assign spi_tx_data_o = tx_cur_q;
  assign busy_o        = busy_q;
  assign rx_last_o     = rx_last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ST_IDLE;
      busy_q     <= 1'b0;
      cnt_q      <= '0;
      dir_q      <= DIR_FULL;
      tx_cur_q   <= DUMMY_BYTE;
      nxt_q      <= '0;
      nxt_vld_q  <= 1'b0;
      nxt_pend_q <= 1'b0;
      pio_go_q   <= 1'b0;
      rx_last_q  <= '0;
    end else begin
      pio_go_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (spi_done_i) rx_last_q <= spi_rx_data_i;
          if (go_i) begin
            busy_q     <= 1'b1;
            cnt_q      <= cnt_init_i;
            dir_q      <= go_dir_i;
            nxt_vld_q  <= 1'b0;
            nxt_pend_q <= 1'b0;
            if (go_dir_i != DIR_RX) begin
              st_q <= ST_LOAD;
            end else begin
              tx_cur_q <= DUMMY_BYTE;
              st_q     <= ST_START;
            end
          end else if (pio_wr_i) begin
            tx_cur_q <= pio_data_i;
            pio_go_q <= master_i;
          end
        end
        ST_LOAD:  st_q <= ST_CAP;
        ST_CAP: begin
          tx_cur_q <= ram_rdata_i;
          st_q     <= ST_START;
        end
        ST_START: st_q <= ST_XFER;
        ST_XFER: begin
          nxt_pend_q <= fetch;
          if (nxt_pend_q) begin
            nxt_q     <= ram_rdata_i;
            nxt_vld_q <= 1'b1;
          end
          if (spi_done_i) begin
            if (last) begin
              busy_q <= 1'b0;
              st_q   <= ST_IDLE;
            end else begin
              cnt_q <= cnt_q - 1'b1;
              st_q  <= ST_START;
              if (tx_act) begin
                if (nxt_vld_q) begin
                  tx_cur_q  <= nxt_q;
                  nxt_vld_q <= 1'b0;
                end else if (nxt_pend_q) begin
                  tx_cur_q  <= ram_rdata_i;
                  nxt_vld_q <= 1'b0;
                end else begin
                  st_q <= ST_LOAD;
                end
              end
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R9: the RAM port is silent whenever no block transfer runs
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    !busy_q |-> !ram_re_o && !ram_we_o);
  // R4: transmit-only never writes RAM
  p_txonly_nowrite_r4: assert property (@(posedge clk) disable iff (rst)
    (busy_q && dir_q == DIR_TX) |-> !ram_we_o);
  // R5: receive-only never reads RAM and only shifts the dummy byte
  p_rxonly_dummy_r5: assert property (@(posedge clk) disable iff (rst)
    (busy_q && dir_q == DIR_RX) |-> !ram_re_o && spi_tx_data_o == DUMMY_BYTE);
  // R2: each non-final exchange takes one off the remaining count
  p_count_step_r2: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_XFER && spi_done_i && !last) |=> cnt_q == $past(cnt_q) - 1'b1);
  // R1: the exchange that finds the count at zero ends the transfer
  p_finish_r1: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_XFER && spi_done_i && last) |=> !busy_q);
  // R3: read and write never share the single RAM port
  p_port_excl_r3: assert property (@(posedge clk) disable iff (rst)
    !(ram_re_o && ram_we_o));
endmodule

// File: rtl/spi_dma_ctrl.sv
module spi_dma_ctrl
  import spi_dma_pkg::*;
#(
  parameter int AW = 12,
  parameter int CW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_wr,
  input  logic [2:0]    reg_addr,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata,
  output logic          irq,
  output logic          spi_master,
  output logic          spi_start,
  output logic [7:0]    spi_tx_data,
  input  logic          spi_done,
  input  logic [7:0]    spi_rx_data,
  output logic [AW-1:0] ram_addr,
  output logic          ram_re,
  output logic          ram_we,
  output logic [7:0]    ram_wdata,
  input  logic [7:0]    ram_rdata
);
  logic          busy, done, tx_step, rx_step, wr_ok, go, ctrl_wr;
  logic          flag_q, master_q;
  logic [1:0]    dir_q;
  logic [7:0]    rdata_q, rx_last;
  logic [AW-1:0] tx_ptr, rx_ptr;
  logic [CW-1:0] cnt_reg;

  assign wr_ok   = reg_wr && !busy;
  assign ctrl_wr = reg_wr && (reg_addr == A_CTRL);
  assign go      = wr_ok && (reg_addr == A_CTRL) && reg_wdata[0];

  spi_dma_bytereg #(.W(AW)) u_txp (
    .clk(clk), .rst(rst), .wdata(reg_wdata), .step(tx_step), .q(tx_ptr),
    .wr_lo(wr_ok && reg_addr == A_TXLO), .wr_hi(wr_ok && reg_addr == A_TXHI));
  spi_dma_bytereg #(.W(AW)) u_rxp (
    .clk(clk), .rst(rst), .wdata(reg_wdata), .step(rx_step), .q(rx_ptr),
    .wr_lo(wr_ok && reg_addr == A_RXLO), .wr_hi(wr_ok && reg_addr == A_RXHI));
  spi_dma_bytereg #(.W(CW)) u_cnt (
    .clk(clk), .rst(rst), .wdata(reg_wdata), .step(1'b0), .q(cnt_reg),
    .wr_lo(wr_ok && reg_addr == A_CNTLO), .wr_hi(wr_ok && reg_addr == A_CNTHI));

  spi_dma_seq #(.CW(CW)) u_seq (
    .clk(clk), .rst(rst), .go_i(go), .go_dir_i(reg_wdata[2:1]),
    .master_i(master_q), .cnt_init_i(cnt_reg),
    .pio_wr_i(wr_ok && reg_addr == A_DATA), .pio_data_i(reg_wdata),
    .spi_done_i(spi_done), .spi_rx_data_i(spi_rx_data), .ram_rdata_i(ram_rdata),
    .busy_o(busy), .done_o(done), .spi_start_o(spi_start),
    .spi_tx_data_o(spi_tx_data), .ram_re_o(ram_re), .ram_we_o(ram_we),
    .rx_last_o(rx_last));

  assign tx_step    = ram_re;
  assign rx_step    = ram_we;
  assign ram_addr   = ram_we ? rx_ptr : tx_ptr;
  assign ram_wdata  = spi_rx_data;
  assign spi_master = master_q;
  assign irq        = flag_q;
  assign reg_rdata  = rdata_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q   <= 1'b0;
      master_q <= 1'b0;
      dir_q    <= DIR_FULL;
    end else begin
      if (done)                           flag_q <= 1'b1;
      else if (ctrl_wr && reg_wdata[7])   flag_q <= 1'b0;
      if (wr_ok && reg_addr == A_CTRL) begin
        dir_q    <= reg_wdata[2:1];
        master_q <= reg_wdata[3];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else begin
      unique case (reg_addr)
        A_CTRL:  rdata_q <= {flag_q, 3'b000, master_q, dir_q, busy};
        A_TXLO:  rdata_q <= tx_ptr[7:0];
        A_TXHI:  rdata_q <= 8'(tx_ptr >> 8);
        A_RXLO:  rdata_q <= rx_ptr[7:0];
        A_RXHI:  rdata_q <= 8'(rx_ptr >> 8);
        A_CNTLO: rdata_q <= cnt_reg[7:0];
        A_CNTHI: rdata_q <= 8'(cnt_reg >> 8);
        default: rdata_q <= rx_last;
      endcase
    end
  end

  // R8: the interrupt is up by the cycle the enable bit has dropped
  p_irq_on_finish_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> irq);
  // R10: programmed count cannot move while a transfer runs
  p_cnt_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(cnt_reg));
endmodule

// File: tb/sim_spi_dma_ctrl.sv
module sim_spi_dma_ctrl;
  logic        clk = 0, rst = 1;
  logic        reg_wr = 0;
  logic [2:0]  reg_addr = 0;
  logic [7:0]  reg_wdata = 0, reg_rdata;
  logic        irq, spi_master, spi_start;
  logic [7:0]  spi_tx_data;
  logic        spi_done = 0;
  logic [7:0]  spi_rx_data = 0;
  logic [11:0] ram_addr;
  logic        ram_re, ram_we;
  logic [7:0]  ram_wdata, ram_rdata = 0;

  always #10 clk = ~clk;

  spi_dma_ctrl u0 (.*);

  int errors = 0, checks = 0;
  logic [7:0] mem [0:4095];
  logic [7:0] rx_log [0:2047];
  int  b_dir = 0, tx_base = 0, rx_base = 0, total = 0;
  bit  b_master = 1, b_loop = 0, dma_on = 0, want_start = 0;
  int  nfires = 0, idx_tx = 0, widx = 0, timer = 0, slave_left = 0, sp_cnt = 0;
  logic [7:0] latched = 0, pio_byte = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (ram_we) mem[ram_addr] <= ram_wdata;
    if (ram_re) ram_rdata <= mem[ram_addr];
  end

  function automatic logic [7:0] exp_tx();
    if (!dma_on) return pio_byte;
    if (b_dir == 2) return 8'hFF;
    return mem[12'(tx_base + idx_tx)];
  endfunction

  task automatic fire(input logic [7:0] rx);
    spi_rx_data = rx;
    spi_done = 1;
    rx_log[nfires] = rx;
    nfires++;
  endtask

  // shift-engine model
  always @(negedge clk) begin
    spi_done = 0;
    if (!rst) begin
      if (b_master) begin
        if (spi_start) begin
          chk(spi_tx_data == exp_tx(), "R3 byte sent at start", spi_tx_data, exp_tx());
          if (dma_on) idx_tx++;
          latched = spi_tx_data;
          timer = 4;
        end else if (timer > 0) begin
          timer--;
          if (timer == 0) fire(b_loop ? latched : (latched ^ 8'h3C));
        end
      end else if (slave_left > 0) begin
        sp_cnt--;
        if (sp_cnt == 0) begin
          chk(spi_tx_data == exp_tx(), "R6 byte sent in slave role", spi_tx_data, exp_tx());
          idx_tx++;
          fire(8'h80 ^ 8'(nfires));
          slave_left--;
          sp_cnt = 12;
        end
      end
    end
  end

  // cycle monitor against the model
  always @(negedge clk) begin
    #2;
    if (!rst) begin
      chk(dma_on || (!ram_re && !ram_we), "R9 RAM access while idle", {ram_re, ram_we}, 0);
      if (dma_on && b_dir == 1) chk(!ram_we, "R4 write in transmit-only", ram_we, 0);
      if (dma_on && b_dir == 2) chk(!ram_re, "R5 read in receive-only", ram_re, 0);
      if (!b_master) chk(!spi_start, "R6 start in slave role", spi_start, 0);
      if (ram_we) begin
        chk(ram_addr == 12'(rx_base + widx), "R3 write address", ram_addr, 12'(rx_base + widx));
        chk(ram_wdata == rx_log[widx], "R3 write data", ram_wdata, rx_log[widx]);
        widx++;
      end
      if (want_start) chk(spi_start, "R12 back-to-back start", spi_start, 1);
      want_start = spi_done && b_master && dma_on && (nfires < total);
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic rd16(input logic [2:0] a, output int v);
    logic [7:0] lo, hi;
    rd(a, lo);
    rd(a + 3'd1, hi);
    v = {hi, lo};
  endtask

  task automatic run(input int dir, input bit mst, input int txb, input int rxb,
                     input int cnt, input bit loop, input bit poke);
    int n = cnt + 1;
    int v;
    logic [7:0] c;
    b_dir = dir; b_master = mst; b_loop = loop;
    tx_base = txb; rx_base = rxb; total = n;
    nfires = 0; idx_tx = 0; widx = 0;
    wr(3'd1, 8'(txb)); wr(3'd2, 8'(txb >> 8));
    wr(3'd3, 8'(rxb)); wr(3'd4, 8'(rxb >> 8));
    wr(3'd5, 8'(cnt)); wr(3'd6, 8'(cnt >> 8));
    dma_on = 1;
    wr(3'd0, {4'b0000, mst, 2'(dir), 1'b1});
    if (!mst) begin sp_cnt = 12; slave_left = n; end
    rd(3'd0, c);
    chk(c[0] == 1, "R1 enable reads busy", c[0], 1);
    if (poke) begin
      repeat (40) @(negedge clk);
      wr(3'd1, 8'h77); wr(3'd5, 8'h00); wr(3'd0, {4'b0000, ~mst, 2'b01, 1'b0});
    end
    c = 8'h01;
    for (int i = 0; i < 30000 && c[0]; i++) rd(3'd0, c);
    dma_on = 0;
    chk(c[0] == 0, "R1 enable self-clears", c[0], 0);
    chk(c[7] == 1, "R8 done flag", c[7], 1);
    chk(irq == 1, "R8 irq raised", irq, 1);
    chk(c[2:0] == {2'(dir), 1'b0} && c[3] == mst, "R10 mode kept", c, {mst, 2'(dir), 1'b0});
    chk(nfires == n, "R2 exchange count", nfires, n);
    chk(widx == ((dir == 1) ? 0 : n), "R2 RAM write count", widx, (dir == 1) ? 0 : n);
    rd16(3'd1, v);
    chk(v == ((dir == 2) ? txb : ((txb + n) & 12'hFFF)), "R7 tx pointer", v,
        (dir == 2) ? txb : ((txb + n) & 12'hFFF));
    rd16(3'd3, v);
    chk(v == ((dir == 1) ? rxb : ((rxb + n) & 12'hFFF)), "R7 rx pointer", v,
        (dir == 1) ? rxb : ((rxb + n) & 12'hFFF));
    rd16(3'd5, v);
    chk(v == cnt, "R10 count unchanged", v, cnt);
    wr(3'd0, {1'b1, 3'b000, mst, 2'(dir), 1'b0});
    chk(irq == 0, "R8 flag clear", irq, 0);
  endtask

  initial begin
    logic [7:0] c;
    for (int i = 0; i < 4096; i++) mem[i] = 8'(i * 37 + (i >> 5) + 11);
    repeat (4) @(negedge clk);
    rst = 0;
    rd(3'd0, c);
    chk(c == 8'h00, "R1 reset control", c, 0);
    chk(irq == 0 && spi_start == 0, "R8 reset irq", {irq, spi_start}, 0);

    // R9: single byte without DMA, master role
    wr(3'd0, 8'h08);
    pio_byte = 8'h5A;
    wr(3'd7, 8'h5A);
    repeat (8) @(negedge clk);
    rd(3'd7, c);
    chk(c == 8'h66, "R9 data register receive", c, 8'h66);
    chk(nfires == 1, "R9 one exchange", nfires, 1);

    run(0, 1, 12'h100, 12'h400, 7, 0, 0);       // R3 full-duplex master
    run(0, 1, 12'h200, 12'h600, 19, 1, 0);      // R11 loopback copy
    for (int i = 0; i < 20; i++)
      chk(mem[12'h600 + i] == mem[12'h200 + i], "R11 copy match", mem[12'h600 + i], mem[12'h200 + i]);
    run(1, 1, 12'h300, 12'h700, 4, 0, 0);       // R4 transmit-only
    run(2, 0, 12'h340, 12'hA00, 5, 0, 0);       // R5 receive-only, slave role
    run(0, 0, 12'hFFF, 12'hB00, 0, 0, 0);       // R2 single byte, slave role
    run(0, 1, 12'h000, 12'h800, 1023, 0, 1);    // R2 max count, R10 pokes while busy

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired R1 actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule